// File: doc/BRIEF.md
# Burst Sample-Pair Capture and Serializer

This block sits after an I/O gearing stage that has already turned a double-data-rate converter bus into one 24-bit word per fabric clock. Each word carries two 12-bit samples. The sample in bits [11:0] was taken on the rising edge of the source clock. The sample in bits [23:12] was taken on the falling edge. Everything in the block runs on that single fabric clock and one clock edge.

The block has two operating states:

- `ST_FILL`: each valid word is written into two lane buffers of equal depth, one lane per clock edge. Both lanes share one write pointer.
- `ST_DRAIN`: the block emits the stored samples as a 12-bit valid/ready stream toward a downstream transform engine. For each buffer entry it sends the rising-edge sample first, then the falling-edge sample.

A serial stream of 12 bits per cycle cannot keep up with 24 bits of input per cycle. The block therefore works on bursts.

Transitions between the states:

- `FILL_TO_DRAIN`: taken when the last buffer entry is written.
- `DRAIN_TO_FILL`: taken when the final sample of the burst is accepted downstream.

Words that arrive during `ST_DRAIN` are discarded and counted.

Top module: `burst_pair_serializer`

## Requirements
- R1: A synchronous reset leaves `out_valid` low, `drop_count` zero and the block in `ST_FILL` with both buffers empty; the first burst after reset starts at entry 0.
- R2: In each captured word, bits [11:0] are the rising-edge sample and bits [23:12] are the falling-edge sample.
- R3: In `ST_FILL`, every cycle with `in_valid` high writes both lanes at the same entry, and `out_valid` stays low until DEPTH words have been captured.
- R4: In `ST_DRAIN`, entries are sent in ascending order. Within an entry, the rising-edge sample comes first and the falling-edge sample second, giving 2*DEPTH samples per burst.
- R5: `out_valid` stays high for the whole of `ST_DRAIN`. The stream advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value.
- R6: `out_last` is high exactly while the falling-edge sample of entry DEPTH-1 is presented, and never while `out_valid` is low.
- R7: In the cycle after the last sample is accepted, the block is back in `ST_FILL` with `out_valid` low. The next burst refills from entry 0.
- R8: A word with `in_valid` high during `ST_DRAIN` is discarded. This includes the cycle of the final handshake. Each discarded word increments `drop_count`, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 2*SAMPLE_W | Sample pair: rising-edge sample low, falling-edge sample high |
| in_valid | input | 1 | A sample pair is present on `in_word` |
| out_data | output | SAMPLE_W | Serial sample toward the transform engine |
| out_valid | output | 1 | `out_data` holds a buffered sample |
| out_ready | input | 1 | Downstream accepts the sample this cycle |
| out_last | output | 1 | The presented sample is the final one of the burst |
| drop_count | output | DROP_W | Saturating count of words discarded during drain |

## Verification
If the lane select is wrong, the two samples of an entry swap places, and `out_data` disagrees with the expected order on the first entry of the burst. If a pointer is off by one, a burst comes out one entry short or long: `out_last` appears at the wrong sample, or `out_valid` falls too early or too late, and this is visible within one burst of 2*DEPTH accepted samples. A drop counter that counts in the wrong state differs from the expected count on the first word discarded during a drain. A stall that does not hold the output shows up as a changed `out_data` in the very next cycle with `out_ready` low.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } bps_state_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/bps_lane_buf.sv
module bps_lane_buf #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
    import bps_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DROP_W = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              wr_en,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ptr,
    output logic              lane_sel,
    output logic              out_valid,
    output logic              out_last,
    output logic [DROP_W-1:0] drop_count
);

    localparam logic [AW-1:0]     LAST_IDX = AW'(DEPTH - 1);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    bps_state_e state_q, state_d;
    logic       handshake;
    logic       final_take;
    logic       fill_done;

    assign handshake  = out_valid && out_ready;
    assign final_take = handshake && out_last;
    assign fill_done  = wr_en && (wr_ptr == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (fill_done)  state_d = ST_DRAIN;   // FILL_TO_DRAIN
            ST_DRAIN: if (final_take) state_d = ST_FILL;    // DRAIN_TO_FILL
            default:  state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        wr_en     = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                wr_en = in_valid;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_last  = lane_sel && (rd_ptr == LAST_IDX);
            end
            default: ;
        endcase
    end

    // pointers, lane select and drop counter
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            lane_sel   <= 1'b0;
            drop_count <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= fill_done ? '0 : wr_ptr + 1'b1;
            end
            if (handshake) begin
                lane_sel <= ~lane_sel;
                if (lane_sel) begin
                    rd_ptr <= final_take ? '0 : rd_ptr + 1'b1;
                end
            end
            if ((state_q == ST_DRAIN) && in_valid && (drop_count != DROP_MAX)) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

    // the falling-edge lane is only ever selected after a rising-edge sample was taken
    assert_lane_order_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_sel) |-> $past(handshake));

    assert_drop_count_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && in_valid && (drop_count != DROP_MAX)) |=> (drop_count == $past(drop_count) + 1'b1));

    assert_no_drop_in_fill_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(drop_count));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && (drop_count == '0) && (wr_ptr == '0) && !lane_sel));

endmodule

// File: rtl/burst_pair_serializer.sv
module burst_pair_serializer
    import bps_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned DROP_W   = 16,
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*SAMPLE_W-1:0] in_word,
    input  logic                  in_valid,
    output logic [SAMPLE_W-1:0]   out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_last,
    output logic [DROP_W-1:0]     drop_count
);

    logic                wr_en;
    logic [AW-1:0]       wr_ptr;
    logic [AW-1:0]       rd_ptr;
    logic                lane_sel;
    logic [SAMPLE_W-1:0] lane_rd [LANES];

    bps_ctrl #(
        .DEPTH  (DEPTH),
        .DROP_W (DROP_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .lane_sel   (lane_sel),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .drop_count (drop_count)
    );

    // lane 0 = rising-edge sample, lane 1 = falling-edge sample
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bps_lane_buf #(
            .W     (SAMPLE_W),
            .DEPTH (DEPTH)
        ) u_buf (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_ptr),
            .wdata (in_word[g*SAMPLE_W +: SAMPLE_W]),
            .raddr (rd_ptr),
            .rdata (lane_rd[g])
        );
    end

    assign out_data = lane_sel ? lane_rd[1] : lane_rd[0];

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_return_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_no_early_drain_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid));

endmodule

// File: tb/burst_pair_serializer_bench.sv
`timescale 1ns/1ps
module burst_pair_serializer_bench;

    localparam int SW     = 12;
    localparam int DEPTH  = 16;
    localparam int DROP_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2*SW-1:0]   in_word = '0;
    logic              in_valid = 1'b0;
    logic              out_ready = 1'b0;
    logic [SW-1:0]     out_data;
    logic              out_valid;
    logic              out_last;
    logic [DROP_W-1:0] drop_count;

    always #2.5 clk = ~clk;

    burst_pair_serializer #(.SAMPLE_W(SW), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_burst_pair_serializer (
        .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .drop_count(drop_count)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    bit       m_drain;
    int       m_fill, m_rd, m_drop;
    bit       m_lane;
    bit [SW-1:0] m_rise [DEPTH];
    bit [SW-1:0] m_fall [DEPTH];

    function automatic bit [SW-1:0] exp_data();
        return m_lane ? m_fall[m_rd] : m_rise[m_rd];
    endfunction

    function automatic bit exp_last();
        return m_drain && m_lane && (m_rd == DEPTH-1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_drain = 0; m_fill = 0; m_rd = 0; m_lane = 0; m_drop = 0;
    endtask

    task automatic model_step(input bit iv, input bit [2*SW-1:0] iw, input bit rdy);
        if (!m_drain) begin
            if (iv) begin
                m_rise[m_fill] = iw[SW-1:0];      // R2 low half is rising edge
                m_fall[m_fill] = iw[2*SW-1:SW];
                if (m_fill == DEPTH-1) begin
                    m_drain = 1; m_fill = 0; m_rd = 0; m_lane = 0;
                end else m_fill++;
            end
        end else begin
            if (iv && m_drop < (1 << DROP_W) - 1) m_drop++;
            if (rdy) begin
                if (m_lane) begin
                    m_lane = 0;
                    if (m_rd == DEPTH-1) begin m_drain = 0; m_rd = 0; end
                    else m_rd++;
                end else m_lane = 1;
            end
        end
    endtask

    task automatic compare();
        check(out_valid == m_drain, "R3/R5/R7 out_valid", out_valid, m_drain);
        if (m_drain) begin
            check(out_data == exp_data(), "R2/R4 out_data order", out_data, exp_data());
        end
        check(out_last == exp_last(), "R6 out_last", out_last, exp_last());
        check(drop_count == DROP_W'(m_drop), "R8 drop_count", drop_count, m_drop);
    endtask

    // one cycle: check current outputs, then drive and advance model
    task automatic cycle(input int pv, input int pr);
        bit iv, rdy;
        bit [2*SW-1:0] iw;
        @(negedge clk);
        compare();
        iv  = ($urandom_range(99) < pv);
        rdy = ($urandom_range(99) < pr);
        iw  = $urandom();
        in_valid = iv; out_ready = rdy; in_word = iw;
        model_step(iv, iw, rdy);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(drop_count == 0, "R1 drop_count after reset", drop_count, 0);
        // directed: full rate in and out
        for (int i = 0; i < 3*(3*DEPTH); i++) cycle(100, 100);
        // R5 long stall
        for (int i = 0; i < 2*DEPTH; i++) cycle(100, 0);
        for (int i = 0; i < 3*DEPTH; i++) cycle(100, 100);
        // random mixes
        for (int i = 0; i < 1500; i++) cycle(60, 50);
        for (int i = 0; i < 1500; i++) cycle(90, 25);
        // R1 mid-drain reset
        while (!m_drain) cycle(100, 0);
        for (int i = 0; i < 3; i++) cycle(0, 100);
        @(negedge clk);
        rst = 1; in_valid = 0; out_ready = 0;
        @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
        check(!out_valid, "R1 out_valid after mid-drain reset", out_valid, 0);
        check(drop_count == 0, "R1 drop_count after mid-drain reset", drop_count, 0);
        for (int i = 0; i < 1000; i++) cycle(80, 70);
        @(negedge clk);
        compare();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule